// File: doc/BRIEF.md
# Set-Associative Instruction Translation Buffer

This block maps instruction-fetch virtual addresses to physical addresses through a small set-associative table of 1 to 4 ways. Each entry has two halves. The match half holds a virtual page tag, a valid flag and a 2-bit usage counter. The translate half holds a physical page number, a cache-inhibit flag, and separate execute permissions for user and supervisor mode. A fetch lookup is combinational. It returns the physical address, the cache-inhibit flag and one of three strobes: hit, page fault or miss. When the fetch is a hit, the usage counters of the addressed set are updated on the next clock edge.

A second lookup port translates an address without raising strobes and without touching any counter. Entries are loaded through a register-style write port, which selects a set, a way and a half. A matching combinational read port returns either half of an entry in the same word layout, so the stored state can be inspected. When translation is switched off, or the unit is built as absent, the address passes through unchanged. In that case the cache-inhibit flag is taken from the top address bit.

Top module: `itlb_xlate`

## Requirements
- R1: When `xlat_en` is 0, or the parameter `PRESENT` is 0, `fetch_pa` equals `fetch_va`, `fetch_ci` equals `fetch_va[31]` (the address is at or above 0x80000000), and none of the three fetch strobes is asserted.
- R2: The set index is `va[OFF_W +: SET_W]` and the tag is `va >> (OFF_W+SET_W)`, where OFF_W = log2(PAGE_BYTES) and SET_W = log2(NSETS). A way hits only when its stored tag equals this tag and its valid flag is 1. In a match word, the tag sits in the bits from OFF_W+SET_W upward, bit 0 is the valid flag, and bits [2:1] are the usage counter.
- R3: On a hit, `fetch_pa` is the entry's physical page number shifted left by OFF_W, OR'd with `va[OFF_W-1:0]`. `fetch_ci` equals the entry's cache-inhibit flag. In a translate word, the page number sits in the bits from OFF_W upward, bit 0 is cache-inhibit, bit 1 is user-execute, and bit 2 is supervisor-execute.
- R4: A hit with `sup_mode`=1 and a clear supervisor-execute flag asserts `fetch_fault`. A hit with `sup_mode`=0 and a clear user-execute flag also asserts `fetch_fault`. `fetch_hit` stays asserted alongside `fetch_fault`.
- R5: A requested, enabled lookup with no matching way asserts `fetch_miss`, drives `fetch_pa` to 0 and `fetch_ci` to 0, and leaves every usage counter unchanged.
- R6: On the clock edge after a hit, the hitting way's counter is loaded with USTATES-1. Every other way in the same set that has a nonzero counter is decremented by 1.
- R7: A match-word write to the same set and way in the cycle of a hit wins over the counter update for that way. The other ways in the set still receive their update.
- R8: When several ways in a set match, the highest-numbered way supplies the translation.
- R9: `peek_pa` equals `peek_va` when translation is off. When translation is on, it is the translated address on a permitted hit and 0 on a miss or a permission failure. The peek port never drives a strobe and never changes a counter.
- R10: After reset, every entry reads back as 0 in both halves, so every enabled lookup misses.
- R11: `rd_data` combinationally returns the addressed entry's match word (`rd_sel`=0) or translate word (`rd_sel`=1), in the layouts of R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xlat_en | input | 1 | Translation enable |
| sup_mode | input | 1 | 1 = supervisor mode, 0 = user mode |
| fetch_req | input | 1 | Fetch lookup valid |
| fetch_va | input | 32 | Fetch virtual address |
| fetch_pa | output | 32 | Fetch physical address |
| fetch_ci | output | 1 | Cache-inhibit for the fetch |
| fetch_hit | output | 1 | Fetch hit strobe |
| fetch_fault | output | 1 | Execute-permission fault strobe |
| fetch_miss | output | 1 | Fetch miss strobe |
| peek_va | input | 32 | Side-effect-free lookup address |
| peek_pa | output | 32 | Side-effect-free lookup result |
| wr_en | input | 1 | Entry write strobe |
| wr_set | input | IDX_W | Set to write |
| wr_way | input | WAY_W | Way to write |
| wr_sel | input | 1 | 0 = match word, 1 = translate word |
| wr_data | input | 32 | Word to write |
| rd_set | input | IDX_W | Set to read |
| rd_way | input | WAY_W | Way to read |
| rd_sel | input | 1 | 0 = match word, 1 = translate word |
| rd_data | output | 32 | Read word |

## Verification
The bench builds the block with 4 KiB pages, 4 sets, 3 ways and 3 usage states. With these values the tag starts at bit 14 and the set index is bits [13:12]. An odd way count exercises a way index that does not fill its field, so the way selection has to cope with unused way codes. Three states put a saturating top value of 2 below the counter's full range. Four sets keep the set index short enough to place aliasing tags deliberately: the bench uses two ways with the same tag for the priority check, plus a same-set, different-tag miss next to counters that are known to be nonzero.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
  localparam int ADDR_W = 32;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef struct packed {
    addr_t      tag;
    addr_t      ppn;
    logic       valid;
    logic [1:0] cnt;
    logic       ci;
    logic       uxe;
    logic       sxe;
  } tlb_ent_t;

  function automatic addr_t set_of(addr_t va, int off_w, int nsets);
    return (va >> off_w) & addr_t'(nsets - 1);
  endfunction

  function automatic addr_t tag_of(addr_t va, int off_w, int set_w);
    return va >> (off_w + set_w);
  endfunction

  function automatic addr_t join_pa(addr_t ppn, addr_t va, int off_w);
    return (ppn << off_w) | (va & ((addr_t'(1) << off_w) - addr_t'(1)));
  endfunction

  function automatic addr_t pack_match(tlb_ent_t e, int off_w, int set_w);
    return (e.tag << (off_w + set_w)) | addr_t'({e.cnt, e.valid});
  endfunction

  function automatic addr_t pack_xlat(tlb_ent_t e, int off_w);
    return (e.ppn << off_w) | addr_t'({e.sxe, e.uxe, e.ci});
  endfunction
endpackage

// File: rtl/itlb_way.sv
module itlb_way
  import itlb_pkg::*;
#(
  parameter int NSETS   = 16,
  parameter int OFF_W   = 13,
  parameter int SET_W   = 4,
  parameter int IDX_W   = 4,
  parameter int USTATES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [IDX_W-1:0] wr_set,
  input  addr_t            wr_data,
  input  logic             upd_en,
  input  logic             upd_hit,
  input  logic [IDX_W-1:0] upd_set,
  input  logic [IDX_W-1:0] f_set,
  input  logic [IDX_W-1:0] p_set,
  input  logic [IDX_W-1:0] r_set,
  output tlb_ent_t         f_ent,
  output tlb_ent_t         p_ent,
  output tlb_ent_t         r_ent
);
  localparam logic [1:0] CNT_TOP = 2'(USTATES - 1);

  tlb_ent_t mem [NSETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSETS; i++) mem[i] <= '0;
    end else begin
      // usage update first, so a same-cycle match write overrides it
      if (upd_en) begin
        if (upd_hit)
          mem[upd_set].cnt <= CNT_TOP;
        else if (mem[upd_set].cnt != 2'd0)
          mem[upd_set].cnt <= mem[upd_set].cnt - 2'd1;
      end
      if (wr_en) begin
        if (!wr_sel) begin
          mem[wr_set].tag   <= tag_of(wr_data, OFF_W, SET_W);
          mem[wr_set].valid <= wr_data[0];
          mem[wr_set].cnt   <= wr_data[2:1];
        end else begin
          mem[wr_set].ppn <= wr_data >> OFF_W;
          mem[wr_set].ci  <= wr_data[0];
          mem[wr_set].uxe <= wr_data[1];
          mem[wr_set].sxe <= wr_data[2];
        end
      end
    end
  end

  assign f_ent = mem[f_set];
  assign p_ent = mem[p_set];
  assign r_ent = mem[r_set];
endmodule

// File: rtl/itlb_lookup.sv
module itlb_lookup
  import itlb_pkg::*;
#(
  parameter int NWAYS = 2,
  parameter int WAY_W = 1,
  parameter int OFF_W = 13,
  parameter int SET_W = 4
) (
  input  tlb_ent_t         ents [NWAYS],
  input  addr_t            va,
  input  logic             sup,
  output logic             hit,
  output logic [WAY_W-1:0] way,
  output logic             perm_ok,
  output addr_t            pa,
  output logic             ci
);
  addr_t    want;
  tlb_ent_t sel;

  assign want = tag_of(va, OFF_W, SET_W);

  always_comb begin
    hit = 1'b0;
    way = '0;
    sel = '0;
    // ascending scan: the last (highest) matching way wins
    for (int w = 0; w < NWAYS; w++) begin
      if (ents[w].valid && (ents[w].tag == want)) begin
        hit = 1'b1;
        way = WAY_W'(w);
        sel = ents[w];
      end
    end
  end

  assign perm_ok = sup ? sel.sxe : sel.uxe;
  assign pa      = join_pa(sel.ppn, va, OFF_W);
  assign ci      = sel.ci;
endmodule

// File: rtl/itlb_xlate.sv
module itlb_xlate
  import itlb_pkg::*;
#(
  parameter int PAGE_BYTES = 8192,
  parameter int NSETS      = 16,
  parameter int NWAYS      = 2,
  parameter int USTATES    = 4,
  parameter bit PRESENT    = 1'b1,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int SET_W     = $clog2(NSETS),
  localparam int IDX_W     = (SET_W > 0) ? SET_W : 1,
  localparam int WAY_W     = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xlat_en,
  input  logic             sup_mode,
  input  logic             fetch_req,
  input  logic [31:0]      fetch_va,
  output logic [31:0]      fetch_pa,
  output logic             fetch_ci,
  output logic             fetch_hit,
  output logic             fetch_fault,
  output logic             fetch_miss,
  input  logic [31:0]      peek_va,
  output logic [31:0]      peek_pa,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_set,
  input  logic [WAY_W-1:0] wr_way,
  input  logic             wr_sel,
  input  logic [31:0]      wr_data,
  input  logic [IDX_W-1:0] rd_set,
  input  logic [WAY_W-1:0] rd_way,
  input  logic             rd_sel,
  output logic [31:0]      rd_data
);
  // named internal events (also observed by the bound checker)
  logic             active;
  logic             upd_fire;
  logic [IDX_W-1:0] f_set, p_set;
  logic             f_hit, f_ok, f_ci;
  logic [WAY_W-1:0] f_way;
  addr_t            f_pa;
  logic             p_hit, p_ok, p_ci;
  logic [WAY_W-1:0] p_way;
  addr_t            p_pa;
  tlb_ent_t         fent [NWAYS];
  tlb_ent_t         pent [NWAYS];
  tlb_ent_t         rent [NWAYS];
  tlb_ent_t         rsel;

  assign active = PRESENT && xlat_en;
  assign f_set  = IDX_W'(set_of(fetch_va, OFF_W, NSETS));
  assign p_set  = IDX_W'(set_of(peek_va, OFF_W, NSETS));

  for (genvar gw = 0; gw < NWAYS; gw++) begin : g_way
    itlb_way #(
      .NSETS(NSETS), .OFF_W(OFF_W), .SET_W(SET_W),
      .IDX_W(IDX_W), .USTATES(USTATES)
    ) u_way (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en && (wr_way == WAY_W'(gw))),
      .wr_sel  (wr_sel),
      .wr_set  (wr_set),
      .wr_data (wr_data),
      .upd_en  (upd_fire),
      .upd_hit (f_way == WAY_W'(gw)),
      .upd_set (f_set),
      .f_set   (f_set),
      .p_set   (p_set),
      .r_set   (rd_set),
      .f_ent   (fent[gw]),
      .p_ent   (pent[gw]),
      .r_ent   (rent[gw])
    );
  end

  itlb_lookup #(.NWAYS(NWAYS), .WAY_W(WAY_W), .OFF_W(OFF_W), .SET_W(SET_W)) u_fetch_lk (
    .ents(fent), .va(fetch_va), .sup(sup_mode),
    .hit(f_hit), .way(f_way), .perm_ok(f_ok), .pa(f_pa), .ci(f_ci)
  );

  itlb_lookup #(.NWAYS(NWAYS), .WAY_W(WAY_W), .OFF_W(OFF_W), .SET_W(SET_W)) u_peek_lk (
    .ents(pent), .va(peek_va), .sup(sup_mode),
    .hit(p_hit), .way(p_way), .perm_ok(p_ok), .pa(p_pa), .ci(p_ci)
  );

  // fetch port
  assign fetch_hit   = fetch_req && active && f_hit;
  assign fetch_fault = fetch_hit && !f_ok;
  assign fetch_miss  = fetch_req && active && !f_hit;
  assign upd_fire    = fetch_hit;
  assign fetch_pa    = !active ? fetch_va : (f_hit ? f_pa : '0);
  assign fetch_ci    = !active ? fetch_va[31] : (f_hit && f_ci);

  // side-effect-free port: nothing here reaches state
  logic peek_unused;
  assign peek_unused = p_ci ^ (|p_way);
  assign peek_pa = !active ? peek_va : ((p_hit && p_ok) ? p_pa : '0);

  // read port
  always_comb begin
    rsel = '0;
    for (int w = 0; w < NWAYS; w++)
      if (rd_way == WAY_W'(w)) rsel = rent[w];
  end
  assign rd_data = rd_sel ? pack_xlat(rsel, OFF_W) : pack_match(rsel, OFF_W, SET_W);
endmodule

// File: rtl/itlb_xlate_chk.sv
module itlb_xlate_chk #(
  parameter int NWAYS = 2,
  parameter int WAY_W = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             active,
  input logic [31:0]      fetch_va,
  input logic [31:0]      fetch_pa,
  input logic             fetch_ci,
  input logic             fetch_hit,
  input logic             fetch_fault,
  input logic             fetch_miss,
  input logic [WAY_W-1:0] hit_way
);
  p_bypass_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (fetch_pa == fetch_va) && (fetch_ci == fetch_va[31]) && !fetch_hit && !fetch_miss);

  p_hit_miss_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fetch_hit, fetch_miss}));

  p_fault_needs_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_fault |-> fetch_hit);

  p_miss_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_miss |-> (fetch_pa == 32'd0) && !fetch_ci);

  p_way_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_hit |-> (int'(hit_way) < NWAYS));
endmodule

bind itlb_xlate itlb_xlate_chk #(.NWAYS(NWAYS), .WAY_W(WAY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .fetch_va(fetch_va),
  .fetch_pa(fetch_pa), .fetch_ci(fetch_ci), .fetch_hit(fetch_hit),
  .fetch_fault(fetch_fault), .fetch_miss(fetch_miss), .hit_way(f_way)
);

// File: tb/tb_itlb_xlate.sv
`timescale 1ns/1ps
module tb_itlb_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xlat_en = 1'b0, sup_mode = 1'b0, fetch_req = 1'b0;
  logic [31:0] fetch_va = '0, peek_va = '0, wr_data = '0;
  logic [31:0] fetch_pa, peek_pa, rd_data;
  logic        fetch_ci, fetch_hit, fetch_fault, fetch_miss;
  logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [1:0]  wr_set = '0, wr_way = '0, rd_set = '0, rd_way = '0;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  itlb_xlate #(.PAGE_BYTES(4096), .NSETS(4), .NWAYS(3), .USTATES(3)) dut (
    .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .sup_mode(sup_mode),
    .fetch_req(fetch_req), .fetch_va(fetch_va), .fetch_pa(fetch_pa),
    .fetch_ci(fetch_ci), .fetch_hit(fetch_hit), .fetch_fault(fetch_fault),
    .fetch_miss(fetch_miss), .peek_va(peek_va), .peek_pa(peek_pa),
    .wr_en(wr_en), .wr_set(wr_set), .wr_way(wr_way), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_set(rd_set), .rd_way(rd_way), .rd_sel(rd_sel),
    .rd_data(rd_data)
  );

  typedef struct packed {
    logic        sup;
    logic [31:0] va;
    logic        hit;
    logic        fault;
    logic        miss;
    logic        ci;
    logic [31:0] pa;
  } vec_t;

  // 4 KiB pages, 4 sets: set = va[13:12], tag = va[31:14]
  localparam vec_t VEC [9] = '{
    '{1'b0, 32'h0000_0ABC, 1'b1, 1'b0, 1'b0, 1'b0, 32'h1234_5ABC},
    '{1'b1, 32'h0000_0ABC, 1'b1, 1'b0, 1'b0, 1'b0, 32'h1234_5ABC},
    '{1'b1, 32'h0040_1123, 1'b1, 1'b0, 1'b0, 1'b1, 32'h00AB_C123},
    '{1'b0, 32'h0040_1123, 1'b1, 1'b1, 1'b0, 1'b1, 32'h00AB_C123},
    '{1'b0, 32'h8000_2FFF, 1'b1, 1'b0, 1'b0, 1'b0, 32'h7FFF_FFFF},
    '{1'b1, 32'h8000_2FFF, 1'b1, 1'b1, 1'b0, 1'b0, 32'h7FFF_FFFF},
    '{1'b0, 32'h0000_4ABC, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_0000},
    '{1'b1, 32'h0040_2000, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_0000},
    '{1'b0, 32'h0000_1000, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_0000}
  };

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [1:0] w, logic sel, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_set = s; wr_way = w; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [1:0] s, logic [1:0] w, logic sel, logic [31:0] exp);
    @(negedge clk);
    rd_set = s; rd_way = w; rd_sel = sel;
    #1;
    chk(req, "rd_data", rd_data, exp);
  endtask

  task automatic fetch_chk(string req, logic sup, logic [31:0] va, logic h, logic f,
                           logic m, logic c, logic [31:0] pa);
    @(negedge clk);
    sup_mode = sup; fetch_va = va; fetch_req = 1'b1;
    #1;
    chk(req, "fetch_pa", fetch_pa, pa);
    chk(req, "strobes hit/fault/miss/ci", {28'd0, fetch_hit, fetch_fault, fetch_miss, fetch_ci},
        {28'd0, h, f, m, c});
  endtask

  task automatic fetch_stop();
    @(negedge clk);
    fetch_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state
    rd_chk("R10", 2'd0, 2'd0, 1'b0, 32'h0);
    rd_chk("R10", 2'd2, 2'd2, 1'b1, 32'h0);
    xlat_en = 1'b1;
    fetch_chk("R10", 1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0);
    fetch_stop();

    // load entries
    wr(2'd0, 2'd0, 1'b0, 32'h0000_0001);
    wr(2'd0, 2'd0, 1'b1, 32'h1234_5006);
    wr(2'd1, 2'd1, 1'b0, 32'h0040_0001);
    wr(2'd1, 2'd1, 1'b1, 32'h00AB_C005);
    wr(2'd2, 2'd2, 1'b0, 32'h8000_0001);
    wr(2'd2, 2'd2, 1'b1, 32'h7FFF_F002);
    // R11: read-back layouts
    rd_chk("R11", 2'd1, 2'd1, 1'b0, 32'h0040_0001);
    rd_chk("R11", 2'd1, 2'd1, 1'b1, 32'h00AB_C005);

    // R2 R3 R4 R5: vector table
    for (int i = 0; i < 9; i++)
      fetch_chk("R2/R3/R4/R5", VEC[i].sup, VEC[i].va, VEC[i].hit, VEC[i].fault,
                VEC[i].miss, VEC[i].ci, VEC[i].pa);
    fetch_stop();

    // R1: bypass
    xlat_en = 1'b0;
    fetch_chk("R1", 1'b0, 32'h7FFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, 32'h7FFF_FFFF);
    fetch_chk("R1", 1'b1, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 1'b1, 32'h8000_0000);
    fetch_stop();
    xlat_en = 1'b1;

    // R8: two ways with the same tag in set 3; counters 1, 2, 0
    wr(2'd3, 2'd0, 1'b0, 32'h0000_0003);
    wr(2'd3, 2'd0, 1'b1, 32'h1111_1006);
    wr(2'd3, 2'd1, 1'b0, 32'h0000_0004);
    wr(2'd3, 2'd2, 1'b0, 32'h0000_0001);
    wr(2'd3, 2'd2, 1'b1, 32'h2222_2006);
    fetch_chk("R8", 1'b0, 32'h0000_3010, 1'b1, 1'b0, 1'b0, 1'b0, 32'h2222_2010);
    fetch_stop();
    // R6: way2 loaded to 2, way0 1->0, way1 2->1
    rd_chk("R6", 2'd3, 2'd0, 1'b0, 32'h0000_0001);
    rd_chk("R6", 2'd3, 2'd1, 1'b0, 32'h0000_0002);
    rd_chk("R6", 2'd3, 2'd2, 1'b0, 32'h0000_0005);

    // R5: same set, other tag -> miss, counters untouched
    fetch_chk("R5", 1'b0, 32'h0000_7010, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0);
    fetch_stop();
    rd_chk("R5", 2'd3, 2'd1, 1'b0, 32'h0000_0002);
    rd_chk("R5", 2'd3, 2'd2, 1'b0, 32'h0000_0005);

    // R9: peek port
    @(negedge clk);
    sup_mode = 1'b0;
    peek_va = 32'h0000_3010; #1;
    chk("R9", "peek hit", peek_pa, 32'h2222_2010);
    chk("R9", "no strobes", {29'd0, fetch_hit, fetch_fault, fetch_miss}, 32'h0);
    @(negedge clk);
    peek_va = 32'h0000_7010; #1;
    chk("R9", "peek miss", peek_pa, 32'h0);
    @(negedge clk);
    peek_va = 32'h0040_1123; #1;
    chk("R9", "peek perm fail", peek_pa, 32'h0);
    @(negedge clk);
    xlat_en = 1'b0; #1;
    chk("R9", "peek bypass", peek_pa, 32'h0040_1123);
    @(negedge clk);
    xlat_en = 1'b1;
    rd_chk("R9", 2'd3, 2'd2, 1'b0, 32'h0000_0005);
    rd_chk("R9", 2'd3, 2'd1, 1'b0, 32'h0000_0002);

    // R7: match write to the hitting way in the hit cycle wins
    @(negedge clk);
    sup_mode = 1'b0; fetch_va = 32'h0000_3010; fetch_req = 1'b1;
    wr_en = 1'b1; wr_set = 2'd3; wr_way = 2'd2; wr_sel = 1'b0; wr_data = 32'h0000_0007;
    @(negedge clk);
    fetch_req = 1'b0; wr_en = 1'b0;
    rd_chk("R7", 2'd3, 2'd2, 1'b0, 32'h0000_0007);
    rd_chk("R7", 2'd3, 2'd1, 1'b0, 32'h0000_0000);
    rd_chk("R7", 2'd3, 2'd0, 1'b0, 32'h0000_0001);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule